// File: doc/BRIEF.md
# Bit Mask to Vector Element Expander

This combinational unit turns a compact mask into a 128-bit vector in which every element is either all ones or all zeros. The mask can come from three places: the low bits of a 64-bit integer operand, a 16-bit immediate gathered from three fields of the instruction word, or the most significant bit of each element of a 128-bit vector operand (a per-element sign spread). Elements are 8, 16, 32, 64 or 128 bits wide.

A 5-bit operation select picks the source and the element size. The immediate form is recognised from the instruction word itself and takes priority over the select. An unrecognised select raises an illegal-operation flag and forces the output to zero. Decode of the wider instruction stream lies outside the unit. Elements are counted from the least significant end: element i occupies bits [(i+1)*W-1 : i*W] and follows mask bit i.

Top module: `bmx_expander`

## Requirements
- R1: `op_sel` codes 0x00..0x04 select spread mode and codes 0x10..0x14 select integer mode. The low three bits give the element size as 8 << code bits (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit, 4 = 128-bit).
- R2: In integer mode, element i is all ones when `gpr_in[i]` is 1 and all zeros otherwise. The number of elements is 16, 8, 4, 2 or 1 for the sizes 8..128. The most significant element therefore follows the highest used mask bit, and for bytes `gpr_in[15:8]` drives the upper 64-bit half.
- R3: Every element of `vec_out` at the selected size is uniformly all ones or all zeros.
- R4: Bits of `gpr_in` at or above the element count have no effect on `vec_out`.
- R5: When `instr_in[5:1]` equals 5'b01010, immediate mode applies whatever `op_sel` holds. It uses byte elements and the mask {instr_in[15:6], instr_in[20:16], instr_in[0]}, with `instr_in[0]` as mask bit 0.
- R6: In spread mode, element i is all ones when its own most significant bit in `vec_in` is 1. For the 128-bit size, `vec_in[127]` fills all 128 bits.
- R7: Any `op_sel` value outside R1, with no immediate match, sets `illegal_op` to 1 and `vec_out` to zero. Every legal operation keeps `illegal_op` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation select: source family and element size |
| instr_in | input | 32 | Instruction word holding the immediate key and fields |
| gpr_in | input | 64 | Integer operand supplying mask bits |
| vec_in | input | 128 | Vector operand for spread mode |
| vec_out | output | 128 | Expanded element mask vector |
| illegal_op | output | 1 | High for an unrecognised select |

## Verification
The bench aims at the bit-to-element ordering, which is where a reversed or half-swapped mapping would put upper-half byte masks into the lower half. It sets integer bits above the element count to catch a design that reads past the used mask width and corrupts high elements. It drives immediate words whose select field holds an illegal code, so a design that ignores the override would flag illegal and output zero. It also probes the 128-bit spread and the illegal codes 0x05 and 0x15, the cases that an off-by-one in the size range gets wrong.

// File: rtl/bmx_pkg.sv
package bmx_pkg;
    localparam int VEC_W   = 128;
    localparam int LANE_W  = 8;
    localparam int NLANES  = VEC_W / LANE_W;
    localparam int NSIZES  = $clog2(NLANES) + 1;
    localparam int SEL_W   = 5;
    localparam int IMM_W   = 16;
    localparam logic [4:0] IMM_KEY = 5'h0A;

    typedef logic [2:0] size_t;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_GPR    = 2'd1,
        SRC_IMM    = 2'd2,
        SRC_SPREAD = 2'd3
    } src_mode_e;
endpackage

// File: rtl/bmx_decode.sv
module bmx_decode
    import bmx_pkg::*;
(
    input  logic [SEL_W-1:0] op_sel,
    input  logic [4:0]       imm_key,
    output src_mode_e        mode,
    output size_t            size,
    output logic             illegal
);
    logic imm_hit;
    logic size_ok;

    assign imm_hit = (imm_key == IMM_KEY);
    assign size_ok = (op_sel[2:0] < size_t'(NSIZES)) && !op_sel[3];

    always_comb begin
        mode    = SRC_NONE;
        size    = '0;
        illegal = 1'b0;
        unique case ({imm_hit, size_ok})
            2'b10, 2'b11: begin
                mode = SRC_IMM;
                size = '0;
            end
            2'b01: begin
                mode = op_sel[4] ? SRC_GPR : SRC_SPREAD;
                size = op_sel[2:0];
            end
            default: begin
                mode    = SRC_NONE;
                illegal = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/bmx_ctrl_bits.sv
module bmx_ctrl_bits
    import bmx_pkg::*;
(
    input  src_mode_e          mode,
    input  size_t              size,
    input  logic [NLANES-1:0]  gpr_low,
    input  logic [IMM_W-1:0]   imm_mask,
    input  logic [VEC_W-1:0]   vec_in,
    output logic [NLANES-1:0]  ctrl
);
    logic [NLANES-1:0] msb_tbl [NSIZES];
    logic [NLANES-1:0] keep;
    logic              unused_vec;

    assign unused_vec = ^vec_in;

    for (genvar s = 0; s < NSIZES; s++) begin : g_size
        localparam int EW = LANE_W << s;
        localparam int NE = NLANES >> s;
        for (genvar i = 0; i < NLANES; i++) begin : g_elem
            if (i < NE) begin : g_live
                assign msb_tbl[s][i] = vec_in[(i+1)*EW-1];
            end else begin : g_dead
                assign msb_tbl[s][i] = 1'b0;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NLANES; i++) begin
            keep[i] = (i < (NLANES >> size));
        end
    end

    always_comb begin
        ctrl = '0;
        unique case (mode)
            SRC_GPR:    ctrl = gpr_low & keep;
            SRC_IMM:    ctrl = imm_mask;
            SRC_SPREAD: ctrl = msb_tbl[size];
            SRC_NONE:   ctrl = '0;
        endcase
    end
endmodule

// File: rtl/bmx_lane_fill.sv
module bmx_lane_fill
    import bmx_pkg::*;
(
    input  size_t              size,
    input  logic [NLANES-1:0]  ctrl,
    output logic [VEC_W-1:0]   vec_out
);
    localparam int LIDX_W = $clog2(NLANES);

    for (genvar b = 0; b < NLANES; b++) begin : g_lane
        logic [LIDX_W-1:0] eidx;
        assign eidx = LIDX_W'(b) >> size;
        assign vec_out[b*LANE_W +: LANE_W] = {LANE_W{ctrl[eidx]}};
    end
endmodule

// File: rtl/bmx_expander.sv
module bmx_expander
    import bmx_pkg::*;
(
    input  logic [SEL_W-1:0] op_sel,
    input  logic [31:0]      instr_in,
    input  logic [63:0]      gpr_in,
    input  logic [VEC_W-1:0] vec_in,
    output logic [VEC_W-1:0] vec_out,
    output logic             illegal_op
);
    src_mode_e         mode;
    size_t             size;
    logic [NLANES-1:0] ctrl;
    logic [IMM_W-1:0]  imm_mask;
    logic              unused_in;

    assign imm_mask  = {instr_in[15:6], instr_in[20:16], instr_in[0]};
    assign unused_in = ^{instr_in[31:21], gpr_in[63:NLANES]};

    bmx_decode u_dec (
        .op_sel  (op_sel),
        .imm_key (instr_in[5:1]),
        .mode    (mode),
        .size    (size),
        .illegal (illegal_op)
    );

    bmx_ctrl_bits u_ctrl (
        .mode     (mode),
        .size     (size),
        .gpr_low  (gpr_in[NLANES-1:0]),
        .imm_mask (imm_mask),
        .vec_in   (vec_in),
        .ctrl     (ctrl)
    );

    bmx_lane_fill u_fill (
        .size    (size),
        .ctrl    (ctrl),
        .vec_out (vec_out)
    );
endmodule

// File: rtl/bmx_expander_chk.sv
module bmx_expander_chk
    import bmx_pkg::*;
(
    input logic [SEL_W-1:0] op_sel,
    input logic [31:0]      instr_in,
    input logic [63:0]      gpr_in,
    input logic [VEC_W-1:0] vec_in,
    input logic [VEC_W-1:0] vec_out,
    input logic             illegal_op
);
    logic known;
    logic imm;
    assign known = !$isunknown({op_sel, instr_in, gpr_in, vec_in, vec_out, illegal_op});
    assign imm   = (instr_in[5:1] == IMM_KEY);

    always_comb begin
        if (known) begin
            // R7: illegal select leaves nothing set
            a_r7_illegal_zero: assert (!illegal_op || vec_out == '0);
            // R3: each byte lane is uniform
            for (int b = 0; b < NLANES; b++) begin
                a_r3_uniform_lane: assert (vec_out[b*LANE_W +: LANE_W] == '0 ||
                                           vec_out[b*LANE_W +: LANE_W] == '1);
            end
            // R5: immediate bit 0 drives the lowest byte
            if (imm) begin
                a_r5_imm_low_lane: assert (!illegal_op && vec_out[7:0] == {8{instr_in[0]}});
            end
            // R6: 128-bit spread copies the top bit everywhere
            if (!imm && op_sel == 5'h04) begin
                a_r6_quad_spread: assert (vec_out == {VEC_W{vec_in[VEC_W-1]}});
            end
            // R2: byte integer mode, top lane follows mask bit 15
            if (!imm && op_sel == 5'h10) begin
                a_r2_top_lane: assert (vec_out[VEC_W-1 -: 8] == {8{gpr_in[15]}});
            end
        end
    end
endmodule

bind bmx_expander bmx_expander_chk u_chk (
    .op_sel     (op_sel),
    .instr_in   (instr_in),
    .gpr_in     (gpr_in),
    .vec_in     (vec_in),
    .vec_out    (vec_out),
    .illegal_op (illegal_op)
);

// File: tb/bmx_expander_test.sv
module bmx_expander_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [4:0]   op_sel;
    logic [31:0]  instr_in;
    logic [63:0]  gpr_in;
    logic [127:0] vec_in;
    logic [127:0] vec_out;
    logic         illegal_op;
    int           n_cmp = 0;
    int           n_bad = 0;
    bit           done = 0;

    always #5 clk = ~clk;

    bmx_expander uut (
        .op_sel(op_sel), .instr_in(instr_in), .gpr_in(gpr_in),
        .vec_in(vec_in), .vec_out(vec_out), .illegal_op(illegal_op)
    );

    localparam int NV = 8;
    localparam logic [4:0]   T_OP  [NV] = '{5'h10, 5'h11, 5'h13, 5'h14, 5'h00, 5'h02, 5'h1F, 5'h12};
    localparam logic [31:0]  T_IN  [NV] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0016CCD5, 32'h0};
    localparam logic [63:0]  T_GPR [NV] = '{64'hFFFF_0000_0000_81A5, 64'h0000_0000_0000_FF5A,
                                           64'h0, 64'h3, 64'h0, 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFF9};
    localparam logic [127:0] T_VEC [NV] = '{128'h0, 128'h0, 128'h0, 128'h0,
                                           128'h80_7F_FF_00_01_90_12_C3_00_80_00_00_7F_FE_AA_55,
                                           128'h8000_0000_7FFF_FFFF_FFFF_0000_0000_0001,
                                           128'h0, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF};

    function automatic void ref_model(input logic [4:0] op, input logic [31:0] ins,
                                      input logic [63:0] g, input logic [127:0] v,
                                      output logic [127:0] o, output logic ill);
        logic [15:0] m16;
        int w;
        o = '0; ill = 1'b0;
        if (ins[5:1] == 5'b01010) begin
            m16 = {ins[15:6], ins[20:16], ins[0]};
            for (int e = 0; e < 16; e++) o[e*8 +: 8] = {8{m16[e]}};
        end else if (op <= 5'h04 || (op >= 5'h10 && op <= 5'h14)) begin
            w = 8 << op[2:0];
            for (int e = 0; e < 128 / w; e++)
                for (int k = 0; k < w; k++)
                    o[e*w + k] = op[4] ? g[e] : v[e*w + w - 1];
        end else begin
            ill = 1'b1;
        end
    endfunction

    task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp,
                         input logic gi, input logic ei);
        n_cmp++;
        if (got !== exp || gi !== ei) begin
            n_bad++;
            $display("FAIL %s: got %h ill=%b expected %h ill=%b", req, got, gi, exp, ei);
        end
    endtask

    task automatic run(input string req, input logic [4:0] op, input logic [31:0] ins,
                       input logic [63:0] g, input logic [127:0] v);
        logic [127:0] e;
        logic ei;
        @(posedge clk);
        op_sel = op; instr_in = ins; gpr_in = g; vec_in = v;
        @(negedge clk);
        ref_model(op, ins, g, v, e, ei);
        check(req, vec_out, e, illegal_op, ei);
    endtask

    task automatic fixed(input string req, input logic [4:0] op, input logic [31:0] ins,
                         input logic [63:0] g, input logic [127:0] v,
                         input logic [127:0] e, input logic ei);
        @(posedge clk);
        op_sel = op; instr_in = ins; gpr_in = g; vec_in = v;
        @(negedge clk);
        check(req, vec_out, e, illegal_op, ei);
    endtask

    initial begin
        op_sel = '0; instr_in = '0; gpr_in = '0; vec_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset idle", vec_out, '0, illegal_op, 1'b0);
        rst_n = 1'b1;

        for (int t = 0; t < NV; t++) run("R2 R5 R6 table", T_OP[t], T_IN[t], T_GPR[t], T_VEC[t]);

        // Reference sweep over every legal code with several patterns (R1, R2, R6)
        for (int c = 0; c < 32; c++) begin
            for (int p = 0; p < 4; p++) begin
                run("R1 sweep", 5'(c), 32'h0,
                    64'hA5C3_0F96_3C5A_E718 ^ {16{4'(p)}},
                    {4{32'h8F3C_1E07 ^ (32'(p) << (p * 7))}});
            end
        end

        // R4: bits above the element count ignored
        fixed("R4 dword high bits", 5'h13, 32'h0, 64'hFFFF_FFFF_FFFF_FFFC, '0, '0, 1'b0);
        fixed("R4 quad high bits", 5'h14, 32'h0, 64'hFFFF_FFFF_FFFF_FFFE, '0, '0, 1'b0);
        // R2: byte ordering, mask bit 15 -> top byte only
        fixed("R2 top byte", 5'h10, 32'h0, 64'h8000, '0, {8'hFF, 120'h0}, 1'b0);
        fixed("R2 bit 8 -> upper half low byte", 5'h10, 32'h0, 64'h0100, '0, {56'h0, 8'hFF, 64'h0}, 1'b0);
        fixed("R2 half bit 7", 5'h11, 32'h0, 64'h80, '0, {16'hFFFF, 112'h0}, 1'b0);
        // R5: immediate overrides illegal and legal selects
        fixed("R5 imm override illegal", 5'h1F, 32'h0000_0015, 64'hFFFF, '0, 128'hFF, 1'b0);
        fixed("R5 imm high field", 5'h04, 32'h0000_8014, 64'h0, {128{1'b1}}, {8'hFF, 120'h0}, 1'b0);
        fixed("R5 mid field bit", 5'h10, 32'h0001_0014, 64'hFFFF, '0, 128'hFF00, 1'b0);
        // R6: quad spread
        fixed("R6 quad spread", 5'h04, 32'h0, '0, {1'b1, 127'h0}, {128{1'b1}}, 1'b0);
        fixed("R6 quad spread clear", 5'h04, 32'h0, '0, {1'b0, {127{1'b1}}}, '0, 1'b0);
        // R7: illegal codes
        fixed("R7 code 05", 5'h05, 32'h0, '1, '1, '0, 1'b1);
        fixed("R7 code 15", 5'h15, 32'h0, '1, '1, '0, 1'b1);
        fixed("R7 code 08", 5'h08, 32'h0, '1, '1, '0, 1'b1);
        // R3 covered by sweep; explicit word spread check
        fixed("R3 word spread", 5'h02, 32'h0, '0, 128'h8000_0000_0000_0000_FFFF_FFFF_7FFF_FFFF,
              128'hFFFF_FFFF_0000_0000_FFFF_FFFF_0000_0000, 1'b0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule